// File: doc/BRIEF.md
# Floppy Controller Auto-Powerdown Manager

This block decides when a floppy disk controller core may drop into its low-power state and when it has to come back. Three sources can request the low-power state. The first is an automatic mode. It fires once the core has stayed idle through a programmable millisecond window. The second is a powerdown request held in the data-rate register, which takes precedence over the automatic mode. The third is a direct software request, which forces the output high. Host register accesses arrive as decoded events. Some of them wake the core and the rest pass through without effect.

When the core leaves a powerdown state, the block holds a busy flag for a not-ready interval. During that interval the core's internal sequencer prepares to accept commands again. The interval is long at the low data rate, short at the high data rate, and always long when leaving automatic powerdown. The idle window is counted in clock-enable ticks, with a parameter giving the number of ticks per millisecond.

The controller has four states:
- `ST_RUN`: normal operation.
- `ST_AUTO_PD`: automatic powerdown.
- `ST_RATE_PD`: powerdown held by the data-rate register.
- `ST_WAKE`: the not-ready interval.

Its transitions are:
- **idle-entry**: `ST_RUN` to `ST_AUTO_PD`.
- **rate-entry**: any of `ST_RUN`, `ST_AUTO_PD` or `ST_WAKE` to `ST_RATE_PD`.
- **access-wake**: `ST_AUTO_PD` to `ST_WAKE` on a waking access.
- **disable-exit**: `ST_AUTO_PD` to `ST_WAKE` when the enable is cleared.
- **rate-release**: `ST_RATE_PD` to `ST_WAKE`.
- **delay-done**: `ST_WAKE` to `ST_RUN`.
- **soft-reset**: any state to `ST_RUN`.

Top module: `fdc_pwrmgr`

## Requirements
- R1: After reset, powerdown_o and busy_o are both 0.
- R2: Automatic powerdown requires all of the following to hold together:
  - apd_en_i is 1.
  - motor_en_i is all zero.
  - msr_i equals 8'h80.
  - irq_i is 0.
  - hut_done_i is 1.
  - APD_MS*TICKS_PER_MS ticks have been counted since the window last restarted.

  With tick_i high every cycle and the window starting from zero, powerdown_o is still 0 after that many clock edges and is 1 one edge later.
- R3: irq_i high blocks automatic powerdown even while msr_i reads 8'h80.
- R4: Clearing apd_en_i clears the idle window. While in automatic powerdown, clearing it also leaves powerdown through the not-ready interval, and powerdown_o stays 0 while the enable stays clear.
- R5: The block decodes host accesses by register offset. The following accesses wake the core:
  - a write to offset 2 whose data bits [7:4] (the motor enables) are not all zero;
  - any read of offset 4;
  - any read or write of offset 5.

  No other access changes the state, including a read of offset 2 and a write to offset 2 with bits [7:4] all zero.
- R6: A waking access restarts the idle window. Once the not-ready interval has ended, automatic powerdown returns only after a full window.
- R7: While rate_pd_i is 1, the block is in powerdown whatever the automatic mode does. After rate_pd_i falls, the block goes through the not-ready interval and the automatic mode becomes effective again.
- R8: busy_o is 1 for exactly DLY_SLOW cycles after leaving automatic powerdown. After leaving a data-rate powerdown it is 1 for DLY_FAST cycles if rate_fast_i is 1, and for DLY_SLOW cycles otherwise. powerdown_o is 0 while busy_o is 1, unless the direct request holds.
- R9: direct_pd_i at 1 sets powerdown_o to 1 at the next clock edge, in any state.
- R10: soft_rst_i returns the block to normal operation at the next edge. No not-ready interval follows, and the idle window restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Clock-enable tick for the idle window |
| apd_en_i | input | 1 | Automatic powerdown enable |
| direct_pd_i | input | 1 | Direct software powerdown request |
| rate_pd_i | input | 1 | Powerdown bit of the data-rate register |
| rate_fast_i | input | 1 | 1 when the high data rate is selected |
| soft_rst_i | input | 1 | Software reset bit (digital output or data-rate register) |
| motor_en_i | input | NUM_MOTORS | Motor enable bits of the digital output register |
| msr_i | input | 8 | Main status register value |
| irq_i | input | 1 | Controller interrupt line |
| hut_done_i | input | 1 | Head unload timer expired |
| acc_valid_i | input | 1 | Host register access strobe |
| acc_write_i | input | 1 | 1 for a write, 0 for a read |
| acc_reg_i | input | 3 | Register offset of the access |
| acc_wdata_i | input | 8 | Write data of the access |
| powerdown_o | output | 1 | Registered powerdown level to the core |
| busy_o | output | 1 | Not-ready interval after a powerdown exit |

## Verification
The idle-entry path is tried with the conditions removed one at a time. The interrupt-high-with-idle-status case separates a block that checks only the status value from one that also checks the interrupt line. Host accesses are applied in pairs on the same offsets, one waking and one non-waking, such as a motor-setting write against a motor-clear write, and a status read against a status write. These pairs expose a decoder that looks at the offset alone. Constrained random sequences interleave data-rate requests, enable toggling, direct requests and soft resets. They catch a wrong precedence, a wrong delay length, or an idle window that fails to restart.

// File: rtl/fdc_pm_pkg.sv
package fdc_pm_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_AUTO_PD = 2'd1,
        ST_RATE_PD = 2'd2,
        ST_WAKE    = 2'd3
    } pm_state_e;

    // register offsets whose access can wake the core
    localparam logic [2:0] OFS_DOR  = 3'd2;
    localparam logic [2:0] OFS_MSR  = 3'd4;
    localparam logic [2:0] OFS_DATA = 3'd5;

    localparam logic [7:0] MSR_IDLE_VAL = 8'h80;

endpackage

// File: rtl/fdc_pm_wakedec.sv
module fdc_pm_wakedec #(
    parameter int NUM_MOTORS = 4,
    parameter int MOTOR_LSB  = 4
) (
    input  logic       acc_valid_i,
    input  logic       acc_write_i,
    input  logic [2:0] acc_reg_i,
    input  logic [7:0] acc_wdata_i,
    output logic       wake_o
);
    import fdc_pm_pkg::*;

    logic [NUM_MOTORS-1:0] motor_field;
    logic                  dor_hit;
    logic                  msr_hit;
    logic                  data_hit;

    assign motor_field = acc_wdata_i[MOTOR_LSB +: NUM_MOTORS];

    always_comb begin
        dor_hit  = acc_write_i && (acc_reg_i == OFS_DOR) && (|motor_field);
        msr_hit  = !acc_write_i && (acc_reg_i == OFS_MSR);
        data_hit = (acc_reg_i == OFS_DATA);
        wake_o   = acc_valid_i && (dor_hit || msr_hit || data_hit);
    end

endmodule

// File: rtl/fdc_pm_idletimer.sv
module fdc_pm_idletimer #(
    parameter int TICKS_PER_MS = 1000,
    parameter int APD_MS       = 10
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic tick_i,
    output logic expired_o
);
    localparam int LIMIT = TICKS_PER_MS * APD_MS;
    localparam int CW    = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != LIMIT_V)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q == LIMIT_V);

endmodule

// File: rtl/fdc_pm_rdydelay.sv
module fdc_pm_rdydelay #(
    parameter int DLY_SLOW = 400,
    parameter int DLY_FAST = 200
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic short_i,
    input  logic run_i,
    output logic done_o
);
    localparam int DW = $clog2(DLY_SLOW + 1);
    localparam logic [DW-1:0] SLOW_LD = DW'(DLY_SLOW - 1);
    localparam logic [DW-1:0] FAST_LD = DW'(DLY_FAST - 1);

    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= short_i ? FAST_LD : SLOW_LD;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/fdc_pwrmgr.sv
module fdc_pwrmgr #(
    parameter int TICKS_PER_MS = 1000,
    parameter int APD_MS       = 10,
    parameter int DLY_SLOW     = 400,
    parameter int DLY_FAST     = 200,
    parameter int NUM_MOTORS   = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  tick_i,
    input  logic                  apd_en_i,
    input  logic                  direct_pd_i,
    input  logic                  rate_pd_i,
    input  logic                  rate_fast_i,
    input  logic                  soft_rst_i,
    input  logic [NUM_MOTORS-1:0] motor_en_i,
    input  logic [7:0]            msr_i,
    input  logic                  irq_i,
    input  logic                  hut_done_i,
    input  logic                  acc_valid_i,
    input  logic                  acc_write_i,
    input  logic [2:0]            acc_reg_i,
    input  logic [7:0]            acc_wdata_i,
    output logic                  powerdown_o,
    output logic                  busy_o
);
    import fdc_pm_pkg::*;

    pm_state_e state_q, state_d;
    logic      wake_ev;
    logic      core_idle;
    logic      win_expired;
    logic      win_clr;
    logic      dly_load;
    logic      dly_short;
    logic      dly_done;
    logic      pd_q;
    logic      busy_q;

    fdc_pm_wakedec #(
        .NUM_MOTORS (NUM_MOTORS),
        .MOTOR_LSB  (4)
    ) u_wake (
        .acc_valid_i (acc_valid_i),
        .acc_write_i (acc_write_i),
        .acc_reg_i   (acc_reg_i),
        .acc_wdata_i (acc_wdata_i),
        .wake_o      (wake_ev)
    );

    // the window runs only in normal operation with the enable set
    assign win_clr = !apd_en_i || wake_ev || soft_rst_i || (state_q != ST_RUN);

    fdc_pm_idletimer #(
        .TICKS_PER_MS (TICKS_PER_MS),
        .APD_MS       (APD_MS)
    ) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (win_clr),
        .tick_i    (tick_i),
        .expired_o (win_expired)
    );

    assign core_idle = (motor_en_i == '0) && (msr_i == MSR_IDLE_VAL)
                     && !irq_i && hut_done_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (soft_rst_i) begin
            state_d = ST_RUN;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (rate_pd_i)
                        state_d = ST_RATE_PD;
                    else if (apd_en_i && core_idle && win_expired && !wake_ev)
                        state_d = ST_AUTO_PD;
                end
                ST_AUTO_PD: begin
                    if (rate_pd_i)
                        state_d = ST_RATE_PD;
                    else if (wake_ev || !apd_en_i)
                        state_d = ST_WAKE;
                end
                ST_RATE_PD: begin
                    if (!rate_pd_i)
                        state_d = ST_WAKE;
                end
                ST_WAKE: begin
                    if (rate_pd_i)
                        state_d = ST_RATE_PD;
                    else if (dly_done)
                        state_d = ST_RUN;
                end
                default: state_d = ST_RUN;
            endcase
        end
    end

    assign dly_load  = (state_q != ST_WAKE) && (state_d == ST_WAKE);
    assign dly_short = (state_q == ST_RATE_PD) && rate_fast_i;

    fdc_pm_rdydelay #(
        .DLY_SLOW (DLY_SLOW),
        .DLY_FAST (DLY_FAST)
    ) u_delay (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (dly_load),
        .short_i (dly_short),
        .run_i   (state_q == ST_WAKE),
        .done_o  (dly_done)
    );

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pd_q   <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            pd_q   <= direct_pd_i || (state_d == ST_AUTO_PD) || (state_d == ST_RATE_PD);
            busy_q <= (state_d == ST_WAKE);
        end
    end

    assign powerdown_o = pd_q;
    assign busy_o      = busy_q;

endmodule

// File: rtl/fdc_pm_chk.sv
module fdc_pm_chk #(
    parameter int DLY_SLOW   = 400,
    parameter int NUM_MOTORS = 4
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  direct_pd_i,
    input logic                  rate_pd_i,
    input logic                  soft_rst_i,
    input logic [NUM_MOTORS-1:0] motor_en_i,
    input logic                  irq_i,
    input logic                  powerdown_o,
    input logic                  busy_o
);
    localparam int BW = $clog2(DLY_SLOW + 2);

    logic [BW-1:0] busy_run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            busy_run_q <= '0;
        else if (busy_o)
            busy_run_q <= busy_run_q + 1'b1;
        else
            busy_run_q <= '0;
    end

    // R9
    direct_forces_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        direct_pd_i |=> powerdown_o);

    // R2
    motor_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!powerdown_o && !direct_pd_i && !rate_pd_i && (motor_en_i != '0)) |=> !powerdown_o);

    // R3
    irq_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!powerdown_o && !direct_pd_i && !rate_pd_i && irq_i) |=> !powerdown_o);

    // R8
    busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !direct_pd_i |=> !(busy_o && powerdown_o));

    // R8
    busy_from_pd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(powerdown_o));

    // R8
    busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_run_q <= BW'(DLY_SLOW));

    // R10
    soft_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (soft_rst_i && !direct_pd_i) |=> (!powerdown_o && !busy_o));

    // R7
    rate_pd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rate_pd_i && !soft_rst_i) |=> powerdown_o);

endmodule

bind fdc_pwrmgr fdc_pm_chk #(
    .DLY_SLOW   (DLY_SLOW),
    .NUM_MOTORS (NUM_MOTORS)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .direct_pd_i (direct_pd_i),
    .rate_pd_i   (rate_pd_i),
    .soft_rst_i  (soft_rst_i),
    .motor_en_i  (motor_en_i),
    .irq_i       (irq_i),
    .powerdown_o (powerdown_o),
    .busy_o      (busy_o)
);

// File: tb/sim_fdc_pwrmgr.sv
`timescale 1ns/1ps
module sim_fdc_pwrmgr;
    localparam int TPM  = 3;
    localparam int AMS  = 10;
    localparam int WIN  = TPM * AMS;
    localparam int SLOW = 8;
    localparam int FAST = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       apd_en = 1'b0;
    logic       direct_pd = 1'b0;
    logic       rate_pd = 1'b0;
    logic       rate_fast = 1'b0;
    logic       soft_rst = 1'b0;
    logic [3:0] motor = 4'h0;
    logic [7:0] msr = 8'h80;
    logic       irq = 1'b0;
    logic       hut = 1'b1;
    logic       av = 1'b0;
    logic       aw = 1'b0;
    logic [2:0] areg = 3'd0;
    logic [7:0] adat = 8'h00;
    logic       pd;
    logic       busy;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;

    always #10 clk = ~clk;

    fdc_pwrmgr #(
        .TICKS_PER_MS (TPM),
        .APD_MS       (AMS),
        .DLY_SLOW     (SLOW),
        .DLY_FAST     (FAST),
        .NUM_MOTORS   (4)
    ) u0 (
        .clk_i (clk), .rst_ni (rst_n), .tick_i (tick), .apd_en_i (apd_en),
        .direct_pd_i (direct_pd), .rate_pd_i (rate_pd), .rate_fast_i (rate_fast),
        .soft_rst_i (soft_rst), .motor_en_i (motor), .msr_i (msr), .irq_i (irq),
        .hut_done_i (hut), .acc_valid_i (av), .acc_write_i (aw), .acc_reg_i (areg),
        .acc_wdata_i (adat), .powerdown_o (pd), .busy_o (busy)
    );

    // reference model, written from the requirements
    int m_st = 0;   // 0 run, 1 auto, 2 rate, 3 wake
    int m_win = 0;
    int m_dly = 0;
    bit m_pd = 0;
    bit m_busy = 0;

    function automatic bit f_wake(bit v, bit w, logic [2:0] r, logic [7:0] d);
        return v && ((w && r == 3'd2 && d[7:4] != 4'h0) || (!w && r == 3'd4) || r == 3'd5);
    endfunction

    function automatic bit f_idle(logic [3:0] mo, logic [7:0] s, bit i, bit h);
        return mo == 4'h0 && s == 8'h80 && !i && h;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_win = 0; m_dly = 0; m_pd = 0; m_busy = 0;
        end else begin
            bit wk;
            int ns;
            wk = f_wake(av, aw, areg, adat);
            ns = m_st;
            if (soft_rst) ns = 0;
            else if (m_st == 0) begin
                if (rate_pd) ns = 2;
                else if (apd_en && f_idle(motor, msr, irq, hut) && m_win == WIN && !wk) ns = 1;
            end else if (m_st == 1) begin
                if (rate_pd) ns = 2;
                else if (wk || !apd_en) ns = 3;
            end else if (m_st == 2) begin
                if (!rate_pd) ns = 3;
            end else begin
                if (rate_pd) ns = 2;
                else if (m_dly == 0) ns = 0;
            end
            if (m_st != 3 && ns == 3) m_dly = (m_st == 2 && rate_fast) ? FAST - 1 : SLOW - 1;
            else if (m_st == 3 && m_dly != 0) m_dly = m_dly - 1;
            if (!apd_en || wk || soft_rst || m_st != 0) m_win = 0;
            else if (tick && m_win != WIN) m_win = m_win + 1;
            m_pd = direct_pd || ns == 1 || ns == 2;
            m_busy = (ns == 3);
            m_st = ns;
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cmp_on) begin
            chk(pd == m_pd, "R2 model powerdown", pd, m_pd);
            chk(busy == m_busy, "R8 model busy", busy, m_busy);
        end
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic access(bit w, logic [2:0] r, logic [7:0] d);
        av = 1'b1; aw = w; areg = r; adat = d;
        step(1);
        av = 1'b0; aw = 1'b0;
    endtask

    task automatic go_auto();
        int n = 0;
        while (!pd && n < 200) begin step(1); n++; end
    endtask

    int len;

    initial begin
        step(2);
        // R1
        chk(pd == 1'b0, "R1 powerdown at reset", pd, 0);
        chk(busy == 1'b0, "R1 busy at reset", busy, 0);
        rst_n = 1'b1;
        step(1);
        cmp_on = 1'b1;

        // R2: exact entry timing
        apd_en = 1'b1;
        step(WIN);
        chk(pd == 1'b0, "R2 before window end", pd, 0);
        step(1);
        chk(pd == 1'b1, "R2 after window end", pd, 1);

        // R5: non-waking accesses keep powerdown
        access(1'b0, 3'd2, 8'h00);
        chk(pd == 1'b1, "R5 DOR read ignored", pd, 1);
        access(1'b1, 3'd2, 8'h0C);
        chk(pd == 1'b1, "R5 DOR write without motor ignored", pd, 1);
        access(1'b1, 3'd4, 8'hFF);
        chk(pd == 1'b1, "R5 MSR write ignored", pd, 1);
        access(1'b0, 3'd7, 8'h00);
        chk(pd == 1'b1, "R5 other reg ignored", pd, 1);

        // R5 + R8: MSR read wakes, slow delay
        access(1'b0, 3'd4, 8'h00);
        chk(pd == 1'b0 && busy == 1'b1, "R5 MSR read wakes", {pd, busy}, 1);
        len = 0;
        while (busy && len < 50) begin len++; step(1); end
        chk(len == SLOW, "R8 auto exit delay", len, SLOW);
        // R6: full window again
        step(WIN - 2);
        chk(pd == 1'b0, "R6 window restarted", pd, 0);
        go_auto();
        chk(pd == 1'b1, "R6 re-entry", pd, 1);

        // R5: data write wakes, DOR motor write wakes
        access(1'b1, 3'd5, 8'h00);
        chk(busy == 1'b1, "R5 data write wakes", busy, 1);
        step(SLOW);
        go_auto();
        access(1'b1, 3'd2, 8'h10);
        chk(busy == 1'b1, "R5 motor write wakes", busy, 1);
        step(SLOW);

        // R3: irq blocks with MSR idle
        irq = 1'b1;
        step(3 * WIN);
        chk(pd == 1'b0, "R3 irq blocks", pd, 0);
        irq = 1'b0;
        go_auto();

        // R4: clearing enable exits
        apd_en = 1'b0;
        step(1);
        chk(busy == 1'b1 && pd == 1'b0, "R4 disable exits", busy, 1);
        step(3 * WIN);
        chk(pd == 1'b0, "R4 held out", pd, 0);
        apd_en = 1'b1;

        // R7 + R8: rate powerdown override, fast release
        rate_pd = 1'b1; rate_fast = 1'b1;
        step(1);
        chk(pd == 1'b1, "R7 rate pd override", pd, 1);
        access(1'b0, 3'd4, 8'h00);
        chk(pd == 1'b1, "R7 wake ignored in rate pd", pd, 1);
        rate_pd = 1'b0;
        step(1);
        len = 0;
        while (busy && len < 50) begin len++; step(1); end
        chk(len == FAST, "R8 fast rate delay", len, FAST);
        go_auto();
        chk(pd == 1'b1, "R7 auto effective again", pd, 1);

        // R9: direct forces
        apd_en = 1'b0;
        step(SLOW + 2);
        direct_pd = 1'b1;
        step(1);
        chk(pd == 1'b1, "R9 direct forces", pd, 1);
        direct_pd = 1'b0;
        step(1);
        apd_en = 1'b1;
        go_auto();

        // R10: soft reset
        soft_rst = 1'b1;
        step(1);
        soft_rst = 1'b0;
        chk(pd == 1'b0 && busy == 1'b0, "R10 soft reset", {pd, busy}, 0);
        step(WIN - 1);
        chk(pd == 1'b0, "R10 window restarted", pd, 0);

        // random phase
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            tick      = ($urandom % 4) != 0;
            apd_en    = ($urandom % 16) != 0;
            if (($urandom % 40) == 0) rate_pd = ~rate_pd;
            rate_fast = $urandom % 2;
            direct_pd = ($urandom % 50) == 0;
            soft_rst  = ($urandom % 200) == 0;
            motor     = (($urandom % 10) == 0) ? 4'($urandom) : 4'h0;
            msr       = (($urandom % 10) == 0) ? 8'($urandom) : 8'h80;
            irq       = ($urandom % 12) == 0;
            hut       = ($urandom % 10) != 0;
            av        = ($urandom % 15) == 0;
            aw        = $urandom % 2;
            areg      = 3'($urandom);
            adat      = 8'($urandom);
            step(1);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule